// File: doc/BRIEF.md
# Oversampled Serial Data Recovery

This block pulls data bits out of a serial line that a free-running sampler has captured at eight samples per bit. Each cycle of the local clock brings one 40-sample word, so a word normally carries five bits. The local clock follows a reference, not the line, so the bit boundaries slowly drift through the sample word. The block absorbs that drift digitally rather than by steering a clock. It watches where level changes fall, moves a sampling pointer toward the middle of the bits, and emits one bit fewer or one bit more on the cycle after the pointer crosses a word boundary.

The caller feeds one sample word per clock on `word_i`. Sample 0 is the earliest in time and sample 39 the latest. One clock later, the recovered bits appear on `data_o`, right-aligned, together with the number of valid bits on `cnt_o`. A parameter sets how many agreeing cycles of edge evidence the tracker needs before it moves the pointer. This filters jitter on individual edges.

Top module: `osr_data_recover`

## Requirements
- R1: While `rst` is high at a clock edge, the pointer returns to sample position 4, the vote count clears, the stored last sample becomes 0, and the outputs become `data_o` = 0 with `cnt_o` = 5.
- R2: An edge at index i means that sample i differs from the sample before it. For i = 0, that earlier sample is bit 39 of the previous word. Only the lowest-indexed edge in a word is used, and its target position is ((i mod 8) + 4) mod 8.
- R3: Let d = (target − pointer) mod 8. A vote is "up" for d of 1 to 3 and "down" for d of 5 to 7. If d is 0 or 4, there is no vote and the vote count clears. A move changes the pointer by exactly one position, modulo 8.
- R4: When neither wrap case applies, `cnt_o` = 5 and `data_o[k]` = `word_i[8k+p]` for k = 0..4, where p is the pointer in effect for that word.
- R5: When the pointer stepped from 7 to 0 on the previous word, the next word gives `cnt_o` = 4 and `data_o[k]` = `word_i[8(k+1)]` for k = 0..3.
- R6: When the pointer stepped from 0 to 7 on the previous word, the next word gives `cnt_o` = 6, with `data_o[0]` = bit 39 of the previous word and `data_o[k+1]` = `word_i[8k+7]` for k = 0..4.
- R7: The pointer moves only when FILT_LEN consecutive voting words agree in direction; a vote in the other direction restarts the count at 1. A word with no edge leaves the pointer and the vote count unchanged. With FILT_LEN > 1, the pointer never moves on two successive cycles.
- R8: The result for a word appears on the outputs after the first rising clock edge at which that word is presented, and is held until the next edge.
- R9: Bits of `data_o` at or above position `cnt_o` are 0, and `cnt_o` is always 4, 5 or 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local parallel clock, reference-locked |
| rst | input | 1 | Synchronous reset, active high |
| word_i | input | 40 | Raw sample word; bit 0 is earliest |
| data_o | output | 6 | Recovered bits, right-aligned, bit 0 earliest |
| cnt_o | output | 3 | Number of valid bits in `data_o` (4, 5 or 6) |

## Verification
The pointer tracker and the bit picker can act in the same cycle. On the cycle that emits a shortened or lengthened group because of the previous wrap, the tracker may already be counting votes or taking the next step. Likewise, a word with no edges can follow a wrap directly. The bench provokes these overlaps with long streams in which every twelfth bit lasts nine or seven samples, so the pointer keeps wrapping in one direction, and then with streams of mixed 7-, 8- and 9-sample bits. A behavioural reference model built on integer arithmetic predicts every output word, and the bench compares the outputs against it on each clock. The bench also confirms that both the four-bit and the six-bit cases occurred.

// File: rtl/osr_pkg.sv
package osr_pkg;

   typedef enum logic [1:0] {
      PICK_NORM = 2'd0,
      PICK_DROP = 2'd1,
      PICK_ADD  = 2'd2
   } pick_mode_e;

endpackage

// File: rtl/osr_edge_find.sv
module osr_edge_find #(
   parameter int OSR    = 8,
   parameter int WORD_W = 40,
   parameter int PH_W   = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] word_i,
   output logic              any_o,
   output logic [PH_W-1:0]   phase_o,
   output logic              last_o
);

   logic              last_q;
   logic [WORD_W-1:0] edges;

   always_ff @(posedge clk) begin
      if (rst) last_q <= 1'b0;
      else     last_q <= word_i[WORD_W-1];
   end

   // transition between each sample and its predecessor in time
   assign edges  = word_i ^ {word_i[WORD_W-2:0], last_q};
   assign any_o  = |edges;
   assign last_o = last_q;

   // lowest index wins
   always_comb begin
      phase_o = '0;
      for (int i = WORD_W - 1; i >= 0; i--) begin
         if (edges[i]) phase_o = PH_W'(i % OSR);
      end
   end

endmodule

// File: rtl/osr_phase_track.sv
module osr_phase_track
   import osr_pkg::*;
#(
   parameter int OSR         = 8,
   parameter int PH_W        = 3,
   parameter int FILT_LEN    = 2,
   parameter int RESET_PHASE = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            any_i,
   input  logic [PH_W-1:0] edge_ph_i,
   output logic [PH_W-1:0] phase_o,
   output pick_mode_e      mode_o
);

   localparam int HALF = OSR / 2;
   localparam logic [PH_W-1:0] MAXP = PH_W'(OSR - 1);

   logic [PH_W-1:0] phase_q, target, diff;
   logic            up, dn, vote, step;
   pick_mode_e      mode_q;

   assign target = edge_ph_i + PH_W'(HALF);
   assign diff   = target - phase_q;
   assign up     = (diff != '0) && (diff < PH_W'(HALF));
   assign dn     = diff > PH_W'(HALF);
   assign vote   = any_i && (up || dn);

   generate
      if (FILT_LEN == 1) begin : g_nofilt
         assign step = vote;
      end else begin : g_filt
         localparam int CW = $clog2(FILT_LEN + 1);
         logic [CW-1:0] cnt_q, nxt;
         logic          dir_q;
         logic          same;

         assign same = (cnt_q != '0) && (dir_q == dn);
         assign nxt  = same ? cnt_q + 1'b1 : CW'(1);
         assign step = vote && (nxt == CW'(FILT_LEN));

         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
               dir_q <= 1'b0;
            end else if (any_i) begin
               if (!vote) begin
                  cnt_q <= '0;
               end else if (step) begin
                  cnt_q <= '0;
               end else begin
                  cnt_q <= nxt;
                  dir_q <= dn;
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_W'(RESET_PHASE);
         mode_q  <= PICK_NORM;
      end else begin
         if (step) phase_q <= up ? phase_q + 1'b1 : phase_q - 1'b1;
         if (step && up && phase_q == MAXP)      mode_q <= PICK_DROP;
         else if (step && dn && phase_q == '0)   mode_q <= PICK_ADD;
         else                                    mode_q <= PICK_NORM;
      end
   end

   assign phase_o = phase_q;
   assign mode_o  = mode_q;

endmodule

// File: rtl/osr_bit_pick.sv
module osr_bit_pick
   import osr_pkg::*;
#(
   parameter int OSR   = 8,
   parameter int BITS  = 5,
   parameter int PH_W  = 3,
   parameter int OUT_W = 6,
   parameter int CNT_W = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [OSR*BITS-1:0]  word_i,
   input  logic                 last_i,
   input  logic [PH_W-1:0]      phase_i,
   input  pick_mode_e           mode_i,
   output logic [OUT_W-1:0]     data_o,
   output logic [CNT_W-1:0]     cnt_o
);

   logic [BITS-1:0]  pick;
   logic [OUT_W-1:0] nd;
   logic [CNT_W-1:0] nc;

   generate
      for (genvar k = 0; k < BITS; k++) begin : g_slot
         logic [OSR-1:0] slot;
         assign slot    = word_i[k*OSR +: OSR];
         assign pick[k] = slot[phase_i];
      end
   endgenerate

   always_comb begin
      case (mode_i)
         PICK_DROP: begin
            nd = {2'b00, pick[BITS-1:1]};
            nc = CNT_W'(BITS - 1);
         end
         PICK_ADD: begin
            nd = {pick, last_i};
            nc = CNT_W'(BITS + 1);
         end
         default: begin
            nd = {1'b0, pick};
            nc = CNT_W'(BITS);
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         data_o <= '0;
         cnt_o  <= CNT_W'(BITS);
      end else begin
         data_o <= nd;
         cnt_o  <= nc;
      end
   end

endmodule

// File: rtl/osr_data_recover.sv
module osr_data_recover
   import osr_pkg::*;
#(
   parameter  int OSR      = 8,
   parameter  int WORD_W   = 40,
   parameter  int FILT_LEN = 2,
   localparam int BITS     = WORD_W / OSR,
   localparam int PH_W     = $clog2(OSR),
   localparam int OUT_W    = BITS + 1,
   localparam int CNT_W    = $clog2(BITS + 2)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] word_i,
   output logic [OUT_W-1:0]  data_o,
   output logic [CNT_W-1:0]  cnt_o
);

   localparam int RESET_PHASE = OSR / 2;

   generate
      if (OSR < 4 || (1 << PH_W) != OSR) begin : g_bad_osr
         $error("OSR must be a power of two and at least 4");
      end
      if (WORD_W % OSR != 0 || BITS < 2) begin : g_bad_word
         $error("WORD_W must hold at least two whole bit periods");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("FILT_LEN must be at least 1");
      end
   endgenerate

   logic            edge_any;
   logic [PH_W-1:0] edge_ph;
   logic            last_smp;
   logic [PH_W-1:0] phase_q;
   pick_mode_e      pick_mode;

   osr_edge_find #(.OSR(OSR), .WORD_W(WORD_W), .PH_W(PH_W)) u_edge (
      .clk     (clk),
      .rst     (rst),
      .word_i  (word_i),
      .any_o   (edge_any),
      .phase_o (edge_ph),
      .last_o  (last_smp)
   );

   osr_phase_track #(.OSR(OSR), .PH_W(PH_W), .FILT_LEN(FILT_LEN),
                     .RESET_PHASE(RESET_PHASE)) u_track (
      .clk       (clk),
      .rst       (rst),
      .any_i     (edge_any),
      .edge_ph_i (edge_ph),
      .phase_o   (phase_q),
      .mode_o    (pick_mode)
   );

   osr_bit_pick #(.OSR(OSR), .BITS(BITS), .PH_W(PH_W), .OUT_W(OUT_W),
                  .CNT_W(CNT_W)) u_pick (
      .clk     (clk),
      .rst     (rst),
      .word_i  (word_i),
      .last_i  (last_smp),
      .phase_i (phase_q),
      .mode_i  (pick_mode),
      .data_o  (data_o),
      .cnt_o   (cnt_o)
   );

endmodule

// File: rtl/osr_recover_checker.sv
module osr_recover_checker #(
   parameter int OSR      = 8,
   parameter int BITS     = 5,
   parameter int FILT_LEN = 2,
   parameter int PH_W     = 3,
   parameter int OUT_W    = 6,
   parameter int CNT_W    = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             edge_any,
   input logic [PH_W-1:0]  phase,
   input logic [OUT_W-1:0] data_o,
   input logic [CNT_W-1:0] cnt_o
);

   localparam logic [PH_W-1:0] MAXP = PH_W'(OSR - 1);

   // R9: legal count
   a_r9_count_legal: assert property (@(posedge clk) disable iff (rst)
      (cnt_o == CNT_W'(BITS - 1)) || (cnt_o == CNT_W'(BITS)) || (cnt_o == CNT_W'(BITS + 1)));

   // R9: nothing above the valid bits
   a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
      (data_o >> cnt_o) == '0);

   // R3: single-position moves
   a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
      (phase == $past(phase)) || (phase == PH_W'($past(phase) + 1'b1))
      || (phase == PH_W'($past(phase) - 1'b1)));

   // R5: short group after upward wrap
   a_r5_short_after_wrap: assert property (@(posedge clk) disable iff (rst)
      (phase == '0 && $past(phase) == MAXP) |=> (cnt_o == CNT_W'(BITS - 1)));

   // R6: long group after downward wrap
   a_r6_long_after_wrap: assert property (@(posedge clk) disable iff (rst)
      (phase == MAXP && $past(phase) == '0) |=> (cnt_o == CNT_W'(BITS + 1)));

   // R7: no edge, no move
   a_r7_hold_no_edge: assert property (@(posedge clk) disable iff (rst)
      !edge_any |=> (phase == $past(phase)));

   generate
      if (FILT_LEN > 1) begin : g_gap
         // R7: filter forbids back-to-back moves
         a_r7_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
            (phase != $past(phase)) |=> $stable(phase));
      end
   endgenerate

endmodule

bind osr_data_recover osr_recover_checker #(
   .OSR(OSR), .BITS(BITS), .FILT_LEN(FILT_LEN), .PH_W(PH_W),
   .OUT_W(OUT_W), .CNT_W(CNT_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .edge_any (edge_any),
   .phase    (phase_q),
   .data_o   (data_o),
   .cnt_o    (cnt_o)
);

// File: tb/tb_osr_data_recover.sv
`timescale 1ns/1ps
module tb_osr_data_recover;

   localparam int OSR  = 8;
   localparam int WW   = 40;
   localparam int FLEN = 2;
   localparam int NB   = WW / OSR;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [WW-1:0] word_i = '0;
   logic [NB:0]   data_o;
   logic [2:0]    cnt_o;

   always #4 clk = ~clk;

   osr_data_recover #(.OSR(OSR), .WORD_W(WW), .FILT_LEN(FLEN)) dut (
      .clk(clk), .rst(rst), .word_i(word_i), .data_o(data_o), .cnt_o(cnt_o)
   );

   int checks = 0, fails = 0, saw4 = 0, saw6 = 0;
   bit done = 0;
   string sect = "R4";

   // behavioural reference state
   int m_ph = 4, m_dir = 0, m_cnt = 0, m_mode = 0;
   logic m_prev = 1'b0;
   logic sq[$];

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic run_word(input logic [WW-1:0] w);
      logic [NB:0] ed;
      int ec, first, tgt, d, dv, n, nmode;
      string tag;
      ed = '0;
      word_i = w;
      if (m_mode == 1) begin
         ec = NB - 1;
         for (int k = 0; k < NB - 1; k++) ed[k] = w[OSR*(k+1) + m_ph];
      end else if (m_mode == 2) begin
         ec = NB + 1;
         ed[0] = m_prev;
         for (int k = 0; k < NB; k++) ed[k+1] = w[OSR*k + m_ph];
      end else begin
         ec = NB;
         for (int k = 0; k < NB; k++) ed[k] = w[OSR*k + m_ph];
      end
      first = -1;
      for (int i = 0; i < WW; i++) begin
         if (first < 0 && w[i] != ((i == 0) ? m_prev : w[i-1])) first = i;
      end
      nmode = 0;
      if (first >= 0) begin
         tgt = (first % OSR + OSR / 2) % OSR;
         d = (tgt - m_ph + OSR) % OSR;
         dv = (d >= 1 && d < OSR / 2) ? 1 : (d > OSR / 2) ? -1 : 0;
         if (dv == 0) m_cnt = 0;
         else begin
            n = (m_cnt > 0 && m_dir == dv) ? m_cnt + 1 : 1;
            if (n >= FLEN) begin
               if (m_ph == OSR - 1 && dv == 1) nmode = 1;
               if (m_ph == 0 && dv == -1) nmode = 2;
               m_ph = (m_ph + dv + OSR) % OSR;
               m_cnt = 0;
            end else begin
               m_cnt = n;
               m_dir = dv;
            end
         end
      end
      m_mode = nmode;
      m_prev = w[WW-1];
      @(posedge clk);
      @(negedge clk);
      // R8: result visible one edge after the word
      tag = (ec == NB - 1) ? "R5 R8" : (ec == NB + 1) ? "R6 R8" : {sect, " R8"};
      if (ec == NB - 1 && cnt_o == 3'(ec)) saw4++;
      if (ec == NB + 1 && cnt_o == 3'(ec)) saw6++;
      check({tag, " count"}, int'(cnt_o), ec);
      check({tag, " data"}, int'(data_o), int'(ed));
      check("R9 upper bits", int'(data_o >> cnt_o), 0);
   endtask

   task automatic drain();
      logic [WW-1:0] w;
      while (sq.size() >= WW) begin
         for (int i = 0; i < WW; i++) w[i] = sq.pop_front();
         run_word(w);
      end
   endtask

   // nb bits; every 'every'-th bit lasts 'odd' samples, others OSR
   task automatic send(input int nb, input int every, input int odd, input int konst);
      logic v;
      int len;
      for (int b = 0; b < nb; b++) begin
         v = (konst >= 0) ? konst[0] : 1'($urandom_range(0, 1));
         len = (every > 0 && (b % every) == every - 1) ? odd : OSR;
         for (int s = 0; s < len; s++) sq.push_back(v);
      end
      drain();
   endtask

   task automatic send_jitter(input int nb);
      logic v;
      int len;
      for (int b = 0; b < nb; b++) begin
         v = 1'($urandom_range(0, 1));
         len = $urandom_range(OSR - 1, OSR + 1);
         for (int s = 0; s < len; s++) sq.push_back(v);
      end
      drain();
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      check("R1 reset data", int'(data_o), 0);
      check("R1 reset count", int'(cnt_o), NB);
      rst = 1'b0;
      sect = "R4";  send(80, 0, 0, -1);
      sect = "R7";  send(12, 0, 0, 1);       // constant level, no edges
      sect = "R3";  send(1, 1, 11, -1);      // shift of three samples
      send(40, 0, 0, -1);
      sect = "R2";  send(1, 1, 12, -1);      // shift of four: tie, no vote
      send(40, 0, 0, -1);
      sect = "R5";  send(600, 12, 9, -1);    // slow line: upward wraps
      sect = "R6";  send(600, 12, 7, -1);    // fast line: downward wraps
      sect = "R7";  send_jitter(400);
      sect = "R7";  send(8, 0, 0, 0);
      checks++;
      if (saw4 == 0) begin
         fails++;
         $display("FAIL R5 short groups seen: actual %0d expected >0", saw4);
      end
      checks++;
      if (saw6 == 0) begin
         fails++;
         $display("FAIL R6 long groups seen: actual %0d expected >0", saw6);
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule